// File: doc/BRIEF.md
# Receive BIST Pattern Checker

This block sits behind the character decoder of a multi-channel receiver and turns each channel into a built-in self-test checker on request. Each channel has its own enable, and the enables pass through a shared capture stage. While the capture strobe is high, the stage passes the enables straight through. When the strobe falls, it freezes them. A channel whose effective enable is low runs a 9-bit pseudo-random generator. The generator reproduces the 511-character test loop that a matching transmitter sends, and the loop mixes data and special characters.

An enabled channel first hunts for the loop start character. This is the data byte 0x00 with the special flag clear. Once it finds that character, the channel compares every valid decoded character against the generator's prediction. It reports the result as a 3-bit status code. One status code per loop marks the end of the loop and tells whether any mismatch occurred in that loop. A channel that is not in self-test reports ordinary decode status. The decode error flag from the decoder is ignored while the channel is in self-test.

Top module: `rx_bist_checker`

## Requirements
- R1: After reset, status_o is 000 on every channel and every captured enable is 1 (self-test off), even if latch_en_i is low and ch_en_ni is low.
- R2: While latch_en_i is 1, each channel's effective enable follows ch_en_ni at once (0 = self-test on). When latch_en_i falls, the value from the last clock edge is held, and changes on ch_en_ni have no effect until latch_en_i rises again.
- R3: With self-test off, a valid character gives status 111 if code_err_i is set. Otherwise it gives 001 if spec_i is set, and 000 in all other cases.
- R4: Status is registered. It changes only on the clock edge that samples valid_i high, and it holds through cycles with valid_i low.
- R5: The generator state s is 9 bits. It is preset to 9'h1FF, and it steps as s' = {s[7:0], s[8]^s[4]} (x^9+x^5+1, period 511). The expected character {spec, data} is ~s, so the preset state predicts the start character, data 0x00 with spec 0.
- R6: A channel with self-test on and not yet synchronised gives status 011 for each valid character other than the start character. The start character gives 000 and synchronises the channel, and the generator steps once.
- R7: Once synchronised, each valid character is compared with ~s and the generator steps. A match gives 000 and a mismatch gives 101. Cycles with valid_i low do not step the generator.
- R8: With self-test on, code_err_i has no effect on status.
- R9: The character 510 places after the start character (the 511th of the loop) gives 010 if the loop had no mismatch, and 100 if it had any mismatch, that character included. The mismatch memory then clears, and the loop repeats from the start character.
- R10: Turning self-test off returns a channel to the R3 status codes at once. Turning it back on requires a new start character before any comparing happens.
- R11: Channels are independent: traffic and enables on one channel do not change another channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| latch_en_i | input | 1 | Enable capture strobe: transparent when high, holds when low |
| ch_en_ni | input | NCH | Per-channel self-test enable, active low |
| valid_i | input | NCH | Per-channel decoded character strobe |
| spec_i | input | NCH | Special-character flag of the decoded character |
| code_err_i | input | NCH | Decoder code-rule or disparity error flag |
| data_i | input | NCH*DW | Decoded data bytes, channel c at bits [c*DW +: DW] |
| status_o | output | NCH*3 | Per-channel status, channel c at bits [c*3 +: 3] |

## Verification
The properties assume that valid_i, spec_i, data_i and the enables are synchronous to clk_i and settled at the sampling edge. They also assume that latch_en_i only falls after the wanted enable value has been seen by at least one edge. The bench drives every input on the falling clock edge. It holds ch_en_ni steady across at least one rising edge before it drops latch_en_i. It changes ch_en_ni only on falling edges, so the capture stage always sees one settled value. The full 511-character loop is replayed twice: once with one corrupted character and once clean. Decode error flags and idle gaps are scattered through the loop.

// File: rtl/rxbist_pkg.sv
package rxbist_pkg;
  typedef logic [2:0] status_t;

  // normal decode codes
  localparam status_t ST_DATA     = 3'b000;
  localparam status_t ST_SPEC     = 3'b001;
  localparam status_t ST_DECERR   = 3'b111;
  // self-test codes
  localparam status_t ST_MATCH    = 3'b000;
  localparam status_t ST_HUNT     = 3'b011;
  localparam status_t ST_MISS     = 3'b101;
  localparam status_t ST_LOOP_OK  = 3'b010;
  localparam status_t ST_LOOP_ERR = 3'b100;
endpackage

// File: rtl/bist_en_latch.sv
module bist_en_latch #(
  parameter int NCH = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           latch_en_i,
  input  logic [NCH-1:0] en_ni,
  output logic [NCH-1:0] en_no
);
  logic [NCH-1:0] held_q;

  assign en_no = latch_en_i ? en_ni : held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '1;
    else         held_q <= en_no;
  end
endmodule

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int W   = 9,
  parameter int TAP = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         preset_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] s_q;
  logic         fb;

  assign fb      = s_q[W-1] ^ s_q[TAP-1];
  assign state_o = s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       s_q <= '1;
    else if (preset_i) s_q <= '1;
    else if (step_i)   s_q <= {s_q[W-2:0], fb};
  end
endmodule

// File: rtl/bist_chan.sv
module bist_chan
  import rxbist_pkg::*;
#(
  parameter int DW  = 8,
  parameter int TAP = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          valid_i,
  input  logic          spec_i,
  input  logic          err_i,
  input  logic [DW-1:0] data_i,
  output status_t       status_o
);
  localparam int             LW       = DW + 1;
  localparam logic [LW-1:0]  IDX_LAST = LW'((2 ** LW) - 2);
  localparam logic [LW-1:0]  START_CH = '0;

  logic          lock_q, loop_err_q;
  logic [LW-1:0] idx_q, lfsr_s, exp_ch, rx_ch;
  status_t       status_q;
  logic          running, start_hit, step, preset, mismatch, last, err_any;

  assign rx_ch     = {spec_i, data_i};
  assign exp_ch    = ~lfsr_s;
  assign running   = active_i & lock_q;
  assign start_hit = active_i & ~lock_q & valid_i & (rx_ch == START_CH);
  assign step      = (running & valid_i) | start_hit;
  assign preset    = ~(running | start_hit);
  assign mismatch  = rx_ch != exp_ch;
  assign last      = idx_q == IDX_LAST;
  assign err_any   = loop_err_q | mismatch;

  bist_lfsr #(.W(LW), .TAP(TAP)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .preset_i(preset),
    .step_i  (step),
    .state_o (lfsr_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q     <= 1'b0;
      loop_err_q <= 1'b0;
      idx_q      <= '0;
      status_q   <= ST_DATA;
    end else if (!active_i) begin
      lock_q     <= 1'b0;
      loop_err_q <= 1'b0;
      idx_q      <= '0;
      if (valid_i) status_q <= err_i ? ST_DECERR : (spec_i ? ST_SPEC : ST_DATA);
    end else if (!lock_q) begin
      if (valid_i) begin
        if (start_hit) begin
          lock_q     <= 1'b1;
          idx_q      <= LW'(1);
          loop_err_q <= 1'b0;
          status_q   <= ST_MATCH;
        end else begin
          status_q   <= ST_HUNT;
        end
      end
    end else if (valid_i) begin
      if (last) begin
        idx_q      <= '0;
        loop_err_q <= 1'b0;
        status_q   <= err_any ? ST_LOOP_ERR : ST_LOOP_OK;
      end else begin
        idx_q      <= idx_q + LW'(1);
        loop_err_q <= err_any;
        status_q   <= mismatch ? ST_MISS : ST_MATCH;
      end
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/rx_bist_checker.sv
module rx_bist_checker #(
  parameter int NCH = 2,
  parameter int DW  = 8,
  parameter int TAP = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              latch_en_i,
  input  logic [NCH-1:0]    ch_en_ni,
  input  logic [NCH-1:0]    valid_i,
  input  logic [NCH-1:0]    spec_i,
  input  logic [NCH-1:0]    code_err_i,
  input  logic [NCH*DW-1:0] data_i,
  output logic [NCH*3-1:0]  status_o
);
  logic [NCH-1:0] en_eff_n;

  bist_en_latch #(.NCH(NCH)) u_en (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .latch_en_i(latch_en_i),
    .en_ni     (ch_en_ni),
    .en_no     (en_eff_n)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bist_chan #(.DW(DW), .TAP(TAP)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .active_i(~en_eff_n[c]),
      .valid_i (valid_i[c]),
      .spec_i  (spec_i[c]),
      .err_i   (code_err_i[c]),
      .data_i  (data_i[c*DW +: DW]),
      .status_o(status_o[c*3 +: 3])
    );
  end
endmodule

// File: rtl/rx_bist_checker_sva.sv
module rx_bist_checker_sva #(
  parameter int NCH = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             latch_en_i,
  input logic [NCH-1:0]   valid_i,
  input logic [NCH-1:0]   en_eff_n,
  input logic [NCH*3-1:0] status_o
);
  p_latch_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_en_i && $past(!latch_en_i)) |-> $stable(en_eff_n));

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i[c] |=> $stable(status_o[c*3 +: 3]));

    p_normal_codes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[c] && en_eff_n[c]) |=>
        (status_o[c*3 +: 3] == 3'b000 || status_o[c*3 +: 3] == 3'b001 ||
         status_o[c*3 +: 3] == 3'b111));

    p_bist_codes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i[c] && !en_eff_n[c]) |=>
        (status_o[c*3 +: 3] != 3'b001 && status_o[c*3 +: 3] != 3'b111));

    p_no_unused_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      status_o[c*3 +: 3] != 3'b110);
  end
endmodule

bind rx_bist_checker rx_bist_checker_sva #(.NCH(NCH)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .latch_en_i(latch_en_i),
  .valid_i   (valid_i),
  .en_eff_n  (en_eff_n),
  .status_o  (status_o)
);

// File: tb/tb_rx_bist_checker.sv
`timescale 1ns/1ps
module tb_rx_bist_checker;
  localparam int NCH = 2;
  localparam int DW  = 8;

  logic              clk = 1'b0;
  logic              rst_ni;
  logic              latch_en_i;
  logic [NCH-1:0]    ch_en_ni, valid_i, spec_i, code_err_i;
  logic [NCH*DW-1:0] data_i;
  logic [NCH*3-1:0]  status_o;

  rx_bist_checker #(.NCH(NCH), .DW(DW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .latch_en_i(latch_en_i), .ch_en_ni(ch_en_ni),
    .valid_i(valid_i), .spec_i(spec_i), .code_err_i(code_err_i),
    .data_i(data_i), .status_o(status_o)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         ch;
    logic [2:0] exp;
    string      tag;
    longint     cyc;
  } item_t;

  item_t  sb_q[$];
  longint cyc = 0;
  int     checks = 0, errors = 0;
  bit     done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: compare one cycle after the driving edge
  always @(negedge clk) begin
    if (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
      item_t it;
      it = sb_q.pop_front();
      chk(it.tag, status_o[it.ch*3 +: 3], it.exp);
    end
  end

  task automatic send(int c, logic sp, logic [7:0] d, logic er, logic [2:0] exp, string tag);
    item_t it;
    @(negedge clk);
    valid_i = '0; spec_i = '0; code_err_i = '0;
    valid_i[c] = 1'b1; spec_i[c] = sp; code_err_i[c] = er;
    data_i[c*DW +: DW] = d;
    it.ch = c; it.exp = exp; it.tag = tag; it.cyc = cyc;
    sb_q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = '0; code_err_i = '0;
    end
  endtask

  function automatic logic [8:0] nx(logic [8:0] s);
    return {s[7:0], s[8] ^ s[4]};
  endfunction

  task automatic run_loop(bit corrupt, logic [2:0] exp_last, string tag);
    logic [8:0] s = 9'h1FF;
    for (int k = 0; k < 511; k++) begin
      logic [8:0] ch = ~s;
      logic [2:0] e = (k == 510) ? exp_last : 3'b000;
      logic       er = (k % 37 == 5);  // R8: error flag on good chars
      if (k % 50 == 25) idle(2);       // R7: gaps do not step
      if (corrupt && k == 100) begin
        ch = ch ^ 9'h001;
        e  = 3'b101;
      end
      send(0, ch[8], ch[7:0], er, e, tag);
      s = nx(s);
    end
    idle(2);
  endtask

  initial begin
    rst_ni = 0; latch_en_i = 0; ch_en_ni = '0;
    valid_i = '0; spec_i = '0; code_err_i = '0; data_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 reset status ch0", status_o[2:0], 3'b000);
    chk("R1 reset status ch1", status_o[5:3], 3'b000);

    // R1/R3: latched enables are off, normal codes
    send(0, 1'b1, 8'h00, 1'b0, 3'b001, "R1 start-like special, BIST off");
    send(0, 1'b0, 8'h00, 1'b0, 3'b000, "R3 data");
    send(1, 1'b1, 8'h7C, 1'b0, 3'b001, "R3 special");
    send(0, 1'b1, 8'h12, 1'b1, 3'b111, "R3 decode error");
    idle(4);
    chk("R4 hold while idle", status_o[2:0], 3'b111);
    chk("R4 hold while idle ch1", status_o[5:3], 3'b001);

    // R2: transparent while strobe high, ch0 on
    @(negedge clk); latch_en_i = 1; ch_en_ni = 2'b10;
    send(0, 1'b0, 8'h55, 1'b0, 3'b011, "R6 hunt non-start");
    send(0, 1'b1, 8'h00, 1'b0, 3'b011, "R6 special 0x00 is not start");
    send(1, 1'b1, 8'hAA, 1'b0, 3'b001, "R11 ch1 unaffected");
    idle(1);
    latch_en_i = 0;
    idle(1);
    ch_en_ni = 2'b11;  // must be ignored
    send(0, 1'b0, 8'h34, 1'b0, 3'b011, "R2 captured enable held");
    send(1, 1'b0, 8'h34, 1'b1, 3'b111, "R2 ch1 stays off");
    idle(2);

    // R5/R6/R7/R8/R9: one loop with an error, then a clean loop
    run_loop(1'b1, 3'b100, "R9 loop with mismatch");
    run_loop(1'b0, 3'b010, "R9 clean loop");

    // R10: disable and re-enable
    @(negedge clk); latch_en_i = 1; ch_en_ni = 2'b11;
    send(0, 1'b1, 8'h3C, 1'b0, 3'b001, "R10 disabled special");
    send(0, 1'b0, 8'h3C, 1'b0, 3'b000, "R10 disabled data");
    @(negedge clk); ch_en_ni = 2'b10;
    begin
      logic [8:0] c1 = ~nx(9'h1FF);
      send(0, c1[8], c1[7:0], 1'b0, 3'b011, "R10 needs new start");
      send(0, 1'b0, 8'h00, 1'b0, 3'b000, "R10 resync on start");
      send(0, c1[8], c1[7:0], 1'b0, 3'b000, "R5 second loop char");
      send(0, c1[8], c1[7:0], 1'b0, 3'b101, "R7 repeat is mismatch");
    end
    idle(3);
    latch_en_i = 0;
    idle(2);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule